// File: doc/BRIEF.md
# Four-Channel Blinking LED Current-Level Controller

This block drives four external LED current sinks. For each channel it produces a 3-bit current level, where 0 means off. Each channel combines three things:

- a blink generator, with a period set in milliseconds and an on-fraction set in 1/32 steps;
- a programmed brightness step;
- an optional soft-start ramp that climbs to the target level one step at a time.

A shared prescaler turns the 32.768 kHz-class block clock into a millisecond tick. The channel blink counters and the ramp timers advance only on that tick.

Software uses a small word-addressed register bus. Each channel owns a block of registers:

- a duty word;
- a period word;
- a drive word, holding the step, the soft-start enable and the soft-start time constant;
- a read-only level status word.

Three shared registers follow the channel blocks. They hold the channel enables, the per-channel clock power-down bits and the per-channel clock-source select. A channel whose clock is powered down, or whose source select is not the local 32 kHz source, freezes its blink counter and outputs level 0. A channel that is clocked but not enabled also outputs level 0.

Top module: `led_sink_ctrl`

## Requirements
- R1: After reset every channel has duty field 31, period field 1000 and drive word 0. The enable and source-select registers read 0, the power-down register reads 4'hF, and every level output is 0.
- R2: Channel c's registers sit at byte address 8*c: duty in bits [12:8] at +0, period in bits [15:0] at +2, drive at +4 and level status at +6. In the drive word, bit 0 enables soft start, bits [2:1] are the time constant and bits [14:12] are the step. The shared registers are enable (bits [3:0]) at 0x20, power-down (bits [3:0]) at 0x22 and source select (bit 10+c for channel c) at 0x24. Unused bits read 0. Unmapped addresses read 0 and ignore writes. Writes take effect on the following clock.
- R3: The millisecond tick alternates between 33 and 32 clock cycles, starting with 33 after reset.
- R4: A clocked channel's blink counter advances on each tick and wraps to 0 after reaching the period field (or anything above it), so one blink period lasts field+1 ms.
- R5: A channel is in its on phase while counter*32 < (duty+1)*(period+1). A duty field of 31 gives a steady on.
- R6: Without soft start, an active channel's level is min(step+1, 6), reached one clock after the channel becomes active or the step is written.
- R7: With soft start, an active channel at level 0 goes to 1 on the next clock. It then rises by one level after each 2^tc ms, where tc is the time-constant field, until it reaches the target. A target below the current level is taken on the next clock.
- R8: A channel whose enable bit is 0 outputs level 0, and its ramp restarts from 0.
- R9: While a channel's power-down bit is 1 or its source-select bit is 1, it outputs level 0 and its blink counter holds its value.
- R10: The level status word reads min(step+1, 6) for a channel that is clocked and enabled, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock (32.768 kHz class) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i (combinational) |
| level_o | output | 12 | Per-channel current level, channel c in bits [3c+2:3c] |

## Verification
Errors in the prescaler or in a blink counter show up as on/off edges of level_o that land one or more milliseconds off. Depending on the duty, this appears within one blink period. A ramp timer that counts wrong moves the first level step by a whole tick interval, so the error is visible within 2^tc ms of enabling. A wrong field decode shows up at once on rdata_o or, one clock after the write, on level_o. Because the bench compares both outputs on every clock, each of these errors is reported in the cycle it first becomes visible.

// File: rtl/led_sink_pkg.sv
package led_sink_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned DUTY_W    = 5;
  localparam int unsigned PER_W     = 16;
  localparam int unsigned STEP_W    = 3;
  localparam int unsigned TC_W      = 2;
  localparam int unsigned LVL_W     = 3;
  localparam int unsigned CH_STRIDE = 8;
  localparam int unsigned DUTY_LSB  = 8;
  localparam int unsigned STEP_LSB  = 12;
  localparam int unsigned TC_LSB    = 1;
  localparam int unsigned SS_BIT    = 0;
  localparam int unsigned SEL_LSB   = 10;
  // per-channel offsets
  localparam int unsigned OFS_DIM   = 0;
  localparam int unsigned OFS_PER   = 2;
  localparam int unsigned OFS_DRV   = 4;
  localparam int unsigned OFS_STAT  = 6;
  // shared offsets past the channel blocks
  localparam int unsigned OFS_EN    = 0;
  localparam int unsigned OFS_GATE  = 2;
  localparam int unsigned OFS_SEL   = 4;

  localparam logic [LVL_W-1:0]  LVL_MAX  = 3'd6;
  localparam logic [DUTY_W-1:0] DUTY_RST = 5'd31;
  localparam logic [PER_W-1:0]  PER_RST  = 16'd1000;

  typedef struct packed {
    logic [DUTY_W-1:0] duty;
    logic [PER_W-1:0]  period;
    logic [STEP_W-1:0] step;
    logic [TC_W-1:0]   tc;
    logic              ss_en;
  } chan_cfg_t;

  function automatic logic [LVL_W-1:0] target_level(input logic [STEP_W-1:0] step);
    logic [STEP_W:0] lvl;
    lvl = {1'b0, step} + 1'b1;
    return (lvl > {1'b0, LVL_MAX}) ? LVL_MAX : lvl[LVL_W-1:0];
  endfunction
endpackage

// File: rtl/led_ms_tick.sv
module led_ms_tick #(
  parameter int unsigned LONG_CYC  = 33,
  parameter int unsigned SHORT_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(LONG_CYC);

  logic [CW-1:0] cnt_q;
  logic          short_q;
  logic [CW-1:0] lim;

  assign lim    = short_q ? CW'(SHORT_CYC - 1) : CW'(LONG_CYC - 1);
  assign tick_o = (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q   <= '0;
      short_q <= ~short_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/led_blink.sv
module led_blink
  import led_sink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [PER_W-1:0]  period_i,
  output logic [PER_W-1:0]  cnt_o,
  output logic              on_o
);
  localparam int unsigned PW = PER_W + DUTY_W + 2;

  logic [PER_W-1:0] cnt_q;
  logic [DUTY_W:0]  duty_p1;
  logic [PER_W:0]   per_p1;
  logic [PW-1:0]    pos, span;

  assign duty_p1 = {1'b0, duty_i} + 1'b1;
  assign per_p1  = {1'b0, period_i} + 1'b1;
  assign pos     = {2'b00, cnt_q, {DUTY_W{1'b0}}};
  assign span    = PW'(duty_p1) * PW'(per_p1);
  assign on_o    = (pos < span);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_ramp.sv
module led_ramp
  import led_sink_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic             ss_en_i,
  input  logic [TC_W-1:0]  tc_i,
  input  logic [LVL_W-1:0] target_i,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int unsigned SC_W = (1 << TC_W) - 1;

  logic [LVL_W-1:0] lvl_q;
  logic [SC_W-1:0]  sc_q, lim;

  assign lim   = SC_W'((32'd1 << tc_i) - 32'd1);
  assign lvl_o = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      sc_q  <= '0;
    end else if (!active_i) begin
      lvl_q <= '0;
      sc_q  <= '0;
    end else if (!ss_en_i) begin
      lvl_q <= target_i;
      sc_q  <= '0;
    end else if (lvl_q == '0) begin
      lvl_q <= LVL_W'(1);
      sc_q  <= '0;
    end else if (lvl_q >= target_i) begin
      lvl_q <= target_i;
      sc_q  <= '0;
    end else if (tick_i) begin
      if (sc_q == lim) begin
        lvl_q <= lvl_q + 1'b1;
        sc_q  <= '0;
      end else begin
        sc_q  <= sc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/led_sink_regs.sv
module led_sink_regs
  import led_sink_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NCH-1:0][LVL_W-1:0]   status_i,
  output chan_cfg_t [NCH-1:0]         cfg_o,
  output logic [NCH-1:0]              en_o,
  output logic [NCH-1:0]              gate_o,
  output logic [NCH-1:0]              sel_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int unsigned SH_BASE = NCH * CH_STRIDE;
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(SH_BASE + OFS_EN);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(SH_BASE + OFS_GATE);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(SH_BASE + OFS_SEL);

  function automatic logic [ADDR_W-1:0] ch_addr(input int unsigned c, input int unsigned ofs);
    return ADDR_W'(c * CH_STRIDE + ofs);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t cfg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q.duty   <= DUTY_RST;
        cfg_q.period <= PER_RST;
        cfg_q.step   <= '0;
        cfg_q.tc     <= '0;
        cfg_q.ss_en  <= 1'b0;
      end else if (wr_en_i) begin
        if (addr_i == ch_addr(c, OFS_DIM)) begin
          cfg_q.duty <= wdata_i[DUTY_LSB +: DUTY_W];
        end else if (addr_i == ch_addr(c, OFS_PER)) begin
          cfg_q.period <= wdata_i[PER_W-1:0];
        end else if (addr_i == ch_addr(c, OFS_DRV)) begin
          cfg_q.step  <= wdata_i[STEP_LSB +: STEP_W];
          cfg_q.tc    <= wdata_i[TC_LSB +: TC_W];
          cfg_q.ss_en <= wdata_i[SS_BIT];
        end
      end
    end
    assign cfg_o[c] = cfg_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= '0;
      gate_o <= '1;
      sel_o  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_EN)   en_o   <= wdata_i[NCH-1:0];
      if (addr_i == A_GATE) gate_o <= wdata_i[NCH-1:0];
      if (addr_i == A_SEL)  sel_o  <= wdata_i[SEL_LSB +: NCH];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ch_addr(c, OFS_DIM))  rdata_o[DUTY_LSB +: DUTY_W] = cfg_o[c].duty;
      if (addr_i == ch_addr(c, OFS_PER))  rdata_o[PER_W-1:0]          = cfg_o[c].period;
      if (addr_i == ch_addr(c, OFS_DRV)) begin
        rdata_o[STEP_LSB +: STEP_W] = cfg_o[c].step;
        rdata_o[TC_LSB +: TC_W]     = cfg_o[c].tc;
        rdata_o[SS_BIT]             = cfg_o[c].ss_en;
      end
      if (addr_i == ch_addr(c, OFS_STAT)) rdata_o[LVL_W-1:0] = status_i[c];
    end
    if (addr_i == A_EN)   rdata_o[NCH-1:0]         = en_o;
    if (addr_i == A_GATE) rdata_o[NCH-1:0]         = gate_o;
    if (addr_i == A_SEL)  rdata_o[SEL_LSB +: NCH]  = sel_o;
  end
endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl
  import led_sink_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LONG_CYC  = 33,
  parameter int unsigned SHORT_CYC = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [NCH*LVL_W-1:0]   level_o
);
  logic                       tick;
  chan_cfg_t [NCH-1:0]        cfg;
  logic [NCH-1:0]             en_q, gate_q, sel_q;
  logic [NCH-1:0]             run, active, on, ss_en;
  logic [NCH-1:0][LVL_W-1:0]  status, ramp_lvl, target;
  logic [NCH-1:0][PER_W-1:0]  blink_cnt;

  led_ms_tick #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  led_sink_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status),
    .cfg_o   (cfg),
    .en_o    (en_q),
    .gate_o  (gate_q),
    .sel_o   (sel_q),
    .rdata_o (rdata_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    // a nonzero source select points at a clock not present here: treat as gated
    assign run[c]    = ~gate_q[c] & ~sel_q[c];
    assign active[c] = run[c] & en_q[c];
    assign ss_en[c]  = cfg[c].ss_en;
    assign target[c] = target_level(cfg[c].step);
    assign status[c] = active[c] ? target[c] : '0;

    led_blink u_blink (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .run_i   (run[c]),
      .duty_i  (cfg[c].duty),
      .period_i(cfg[c].period),
      .cnt_o   (blink_cnt[c]),
      .on_o    (on[c])
    );

    led_ramp u_ramp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .active_i(active[c]),
      .ss_en_i (cfg[c].ss_en),
      .tc_i    (cfg[c].tc),
      .target_i(target[c]),
      .lvl_o   (ramp_lvl[c])
    );

    assign level_o[c*LVL_W +: LVL_W] = (active[c] && on[c]) ? ramp_lvl[c] : '0;
  end
endmodule

// File: rtl/led_sink_ctrl_chk.sv
module led_sink_ctrl_chk
  import led_sink_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       tick,
  input logic [NCH*LVL_W-1:0]       level_o,
  input logic [NCH-1:0]             en_q,
  input logic [NCH-1:0]             gate_q,
  input logic [NCH-1:0]             sel_q,
  input logic [NCH-1:0]             ss_en,
  input logic [NCH-1:0][PER_W-1:0]  blink_cnt,
  input logic [NCH-1:0][LVL_W-1:0]  ramp_lvl
);
  p_tick_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    p_lvl_max_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      level_o[c*LVL_W +: LVL_W] <= LVL_MAX);

    p_off_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_q[c] |-> level_o[c*LVL_W +: LVL_W] == '0);

    p_off_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_q[c] || sel_q[c]) |-> level_o[c*LVL_W +: LVL_W] == '0);

    p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate_q[c] || sel_q[c]) |=> $stable(blink_cnt[c]));

    p_ramp_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ss_en[c] |=> ({1'b0, ramp_lvl[c]} <= {1'b0, $past(ramp_lvl[c])} + 1'b1));
  end
endmodule

bind led_sink_ctrl led_sink_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick     (tick),
  .level_o  (level_o),
  .en_q     (en_q),
  .gate_q   (gate_q),
  .sel_q    (sel_q),
  .ss_en    (ss_en),
  .blink_cnt(blink_cnt),
  .ramp_lvl (ramp_lvl)
);

// File: tb/led_sink_ctrl_tb_top.sv
`timescale 1ns/1ps
module led_sink_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int LONG_CYC = 33;
  localparam int SHORT_CYC = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [11:0] level_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  int m_pc, m_ph, m_en, m_gate, m_sel;
  int m_duty[NCH], m_per[NCH], m_step[NCH], m_tc[NCH], m_ss[NCH];
  int m_cnt[NCH], m_cur[NCH], m_sc[NCH];

  always #4 clk_i = ~clk_i;

  led_sink_ctrl #(.NCH(NCH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .level_o(level_o));

  function automatic int tgt(int c);
    return (m_step[c] + 1 > 6) ? 6 : m_step[c] + 1;
  endfunction
  function automatic bit act(int c);
    return !m_gate[c] && !m_sel[c] && m_en[c];
  endfunction

  task automatic m_reset();
    m_pc = 0; m_ph = 0; m_en = 0; m_gate = 15; m_sel = 0;
    for (int c = 0; c < NCH; c++) begin
      m_duty[c] = 31; m_per[c] = 1000; m_step[c] = 0; m_tc[c] = 0; m_ss[c] = 0;
      m_cnt[c] = 0; m_cur[c] = 0; m_sc[c] = 0;
    end
  endtask

  task automatic m_clock();
    bit tk;
    tk = (m_pc == (m_ph ? SHORT_CYC - 1 : LONG_CYC - 1));
    for (int c = 0; c < NCH; c++) begin
      bit run;
      run = !m_gate[c] && !m_sel[c];
      if (run && tk) m_cnt[c] = (m_cnt[c] >= m_per[c]) ? 0 : m_cnt[c] + 1;
      if (!act(c)) begin m_cur[c] = 0; m_sc[c] = 0; end
      else if (!m_ss[c]) begin m_cur[c] = tgt(c); m_sc[c] = 0; end
      else if (m_cur[c] == 0) begin m_cur[c] = 1; m_sc[c] = 0; end
      else if (m_cur[c] >= tgt(c)) begin m_cur[c] = tgt(c); m_sc[c] = 0; end
      else if (tk) begin
        if (m_sc[c] == (1 << m_tc[c]) - 1) begin m_cur[c]++; m_sc[c] = 0; end
        else m_sc[c]++;
      end
    end
    if (wr_en_i) begin
      int a, d;
      a = addr_i; d = wdata_i;
      if (a < 32) begin
        int c;
        c = a / 8;
        case (a % 8)
          0: m_duty[c] = (d >> 8) & 31;
          2: m_per[c] = d;
          4: begin m_step[c] = (d >> 12) & 7; m_tc[c] = (d >> 1) & 3; m_ss[c] = d & 1; end
          default: ;
        endcase
      end
      else if (a == 32) m_en = d & 15;
      else if (a == 34) m_gate = d & 15;
      else if (a == 36) m_sel = (d >> 10) & 15;
    end
    if (tk) begin m_pc = 0; m_ph ^= 1; end else m_pc++;
  endtask

  function automatic int exp_rd(int a);
    if (a < 32) begin
      int c;
      c = a / 8;
      case (a % 8)
        0: return m_duty[c] << 8;
        2: return m_per[c];
        4: return (m_step[c] << 12) | (m_tc[c] << 1) | m_ss[c];
        6: return act(c) ? tgt(c) : 0;
        default: return 0;
      endcase
    end
    if (a == 32) return m_en;
    if (a == 34) return m_gate;
    if (a == 36) return m_sel << 10;
    return 0;
  endfunction

  task automatic compare();
    int e;
    for (int c = 0; c < NCH; c++) begin
      bit on;
      on = (m_cnt[c] * 32) < ((m_duty[c] + 1) * (m_per[c] + 1));
      e = (act(c) && on) ? m_cur[c] : 0;
      n_cmp++;
      if (int'(level_o[c*3 +: 3]) != e) begin
        n_bad++;
        $display("FAIL %s ch%0d level actual=%0d expected=%0d", tag, c, level_o[c*3 +: 3], e);
      end
    end
    e = exp_rd(addr_i);
    n_cmp++;
    if (int'(rdata_o) != e) begin
      n_bad++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", tag, addr_i, rdata_o, e[15:0]);
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk_i);
    m_clock();
    @(negedge clk_i);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(int a, int d);
    wr_en_i = 1'b1; addr_i = 8'(a); wdata_i = 16'(d);
    step();
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_all(int top);
    for (int a = 0; a <= top; a += 2) begin addr_i = 8'(a); step(); end
  endtask

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset values of every register and of the outputs
    tag = "R1"; rd_all(46);
    // R2: field placement, unused bits, unmapped space
    tag = "R2";
    wr(8'h08, 16'hFFFF); wr(8'h0A, 16'h1234); wr(8'h0C, 16'hFFFF);
    wr(8'h26, 16'hFFFF); wr(8'h05, 16'hFFFF); wr(8'h24, 16'hFFFF);
    rd_all(46);
    wr(8'h24, 0); wr(8'h08, 16'h1F00); wr(8'h0A, 1000); wr(8'h0C, 0);
    // R3/R4: millisecond tick and blink period
    tag = "R3"; wr(8'h22, 0); wr(8'h02, 3); wr(8'h00, 16'h0F00); wr(8'h20, 1);
    addr_i = 8'h06; run(300);
    tag = "R4"; wr(8'h02, 5); run(500);
    // R5: duty shapes
    tag = "R5"; wr(8'h00, 16'h0000); run(300);
    wr(8'h00, 16'h1F00); run(100);
    wr(8'h02, 31); wr(8'h00, 16'h0300); run(1200);
    wr(8'h02, 3); wr(8'h00, 16'h1F00);
    // R6: level from step, saturation
    tag = "R6"; wr(8'h04, 16'h5000); run(40); wr(8'h04, 16'h7000); run(40);
    wr(8'h04, 16'h2000); run(40);
    // R7: soft start ramps
    tag = "R7"; addr_i = 8'h16;
    wr(8'h14, 16'h5003); wr(8'h20, 5); run(500);
    wr(8'h20, 1); wr(8'h14, 16'h5007); wr(8'h20, 5); run(600);
    wr(8'h14, 16'h1007); run(100);
    wr(8'h14, 16'h6005); run(700);
    // R8: enable masking
    tag = "R8"; wr(8'h20, 0); run(100); wr(8'h20, 15); run(200);
    // R9: clock gating and source select hold the channel
    tag = "R9"; wr(8'h22, 1); run(300); wr(8'h22, 0); run(200);
    wr(8'h24, 16'h2000); run(200); wr(8'h24, 0); run(100);
    // R10: level status readback
    tag = "R10"; wr(8'h22, 2);
    addr_i = 8'h06; step(); addr_i = 8'h0E; step(); addr_i = 8'h16; step(); addr_i = 8'h1E; step();
    wr(8'h22, 0); wr(8'h20, 8); rd_all(46);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL %s watchdog actual=timeout expected=finish", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule